// File: doc/BRIEF.md
# Edge-Triggered Count Capture Unit

This block takes a snapshot of a free-running count when a chosen edge appears on a trigger signal. The trigger comes from one of two places. The first is an external pin that is not tied to the clock. The second is a comparator result that is already synchronous to the clock. The pin is first passed through a chain of synchronizing flip-flops. After that, the chosen trigger can go through an optional noise filter. The filter accepts a new level only after that level has been sampled the same way several clocks in a row. An edge detector then looks at the filtered level. It fires on either the rising edge or the falling edge, as configured.

On each accepted edge, the block loads the current count into its capture register and sets a capture flag. If another edge arrives while the flag is still set, the register takes the newer count and the flag stays set. Software clears the flag by writing a 1 to it. The interrupt request is the flag gated by a mask bit. The counter itself and the comparator are outside this block. The block only receives their values.

Top module: `trig_capture`

## Requirements
- R1: After reset, `capValue` is 0, `capFlag` is 0 and `irqOut` is 0.
- R2: With the pin selected and the filter off, a qualifying pin change loads `capValue` with the `countIn` value sampled at the fourth rising clock edge after the change. `capFlag` rises at that same edge.
- R3: With the comparator selected and the filter off, a qualifying `cmpIn` change is captured at the second rising clock edge after the change.
- R4: With `filtEn`=1, a level is accepted only after four consecutive equal samples. This moves the capture four clock edges later than in R2 and R3. A trigger pulse shorter than four clocks causes no capture.
- R5: `edgeSel`=1 selects the rising edge and `edgeSel`=0 selects the falling edge. An edge of the other polarity leaves `capValue` and `capFlag` unchanged.
- R6: `srcSel`=0 selects `pinIn` and `srcSel`=1 selects `cmpIn`. Activity on the unselected input leaves `capValue` and `capFlag` unchanged.
- R7: If a capture happens while `capFlag` is already 1, `capValue` takes the newer count and `capFlag` stays 1.
- R8: A cycle with `flagWrEn`=1 and `flagWrData`=1 clears `capFlag`. With `flagWrData`=0 the flag is not changed. If a capture and a clear happen at the same clock edge, the capture wins and the flag ends up 1.
- R9: `irqOut` is 1 exactly when `capFlag` is 1 and `maskEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countIn | input | 16 | Free-running count to be captured |
| pinIn | input | 1 | Asynchronous external trigger pin |
| cmpIn | input | 1 | Synchronous comparator result |
| srcSel | input | 1 | Trigger source: 0 pin, 1 comparator |
| edgeSel | input | 1 | Active edge: 1 rising, 0 falling |
| filtEn | input | 1 | Enables the four-sample noise filter |
| maskEn | input | 1 | Interrupt mask for the capture flag |
| flagWrEn | input | 1 | Write strobe for the capture flag |
| flagWrData | input | 1 | Write data; 1 clears the flag |
| capValue | output | 16 | Captured count |
| capFlag | output | 1 | Capture flag |
| irqOut | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach from the ports is a capture and a software clear landing on the same clock edge. The bench uses the comparator source with the filter off, because that path has the shortest and fixed latency of two edges. It raises `cmpIn` and then asserts the clear write during the single cycle just before the capture edge. A second case that needs careful timing is the filter rejecting a pulse three clocks wide, one short of acceptance. The bench also checks latencies by reading a bench-driven count whose value at each edge is known.

// File: rtl/trig_cap_pkg.sv
package trig_cap_pkg;
  localparam int CNT_W_DEF     = 16;
  localparam int SYNC_DEF      = 2;
  localparam int FILT_DEPTH_DEF = 4;

  // Strobes sent from control to the datapath, valid for one cycle.
  typedef struct packed {
    logic capture;  // accepted edge: load count, set flag
    logic clear;    // software write of 1 to the flag
  } cap_strobe_t;
endpackage

// File: rtl/trig_cap_ctrl.sv
module trig_cap_ctrl
  import trig_cap_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEF,
  parameter int FILT_DEPTH  = FILT_DEPTH_DEF
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinIn,
  input  logic        cmpIn,
  input  logic        srcSel,
  input  logic        edgeSel,
  input  logic        filtEn,
  input  logic        flagWrEn,
  input  logic        flagWrData,
  output cap_strobe_t strobes
);
  logic pinSync;
  logic trigSel;
  logic [FILT_DEPTH-1:0] hist;
  logic fLvl;
  logic prevLvl;
  logic allHigh;
  logic allLow;
  logic fLvlNext;

  // Synchronizer chain for the asynchronous pin.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b0;
        else       syncQ <= pinIn;
      end
      assign pinSync = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      end
      assign pinSync = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  // The comparator result is already synchronous, so it bypasses the chain.
  assign trigSel = srcSel ? cmpIn : pinSync;

  // Sample history used by the noise filter.
  generate
    if (FILT_DEPTH == 1) begin : g_hist1
      always_ff @(posedge clk) begin
        if (!rstN) hist <= '0;
        else       hist <= trigSel;
      end
    end else begin : g_histN
      always_ff @(posedge clk) begin
        if (!rstN) hist <= '0;
        else       hist <= {hist[FILT_DEPTH-2:0], trigSel};
      end
    end
  endgenerate

  assign allHigh = &hist;
  assign allLow  = ~|hist;

  always_comb begin
    fLvlNext = fLvl;
    if (!filtEn)      fLvlNext = trigSel;
    else if (allHigh) fLvlNext = 1'b1;
    else if (allLow)  fLvlNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fLvl    <= 1'b0;
      prevLvl <= 1'b0;
    end else begin
      fLvl    <= fLvlNext;
      prevLvl <= fLvl;
    end
  end

  // Edge detector on the filtered level.
  always_comb begin
    strobes.capture = edgeSel ? (fLvl & ~prevLvl) : (~fLvl & prevLvl);
    strobes.clear   = flagWrEn & flagWrData;
  end
endmodule

// File: rtl/trig_cap_dp.sv
module trig_cap_dp
  import trig_cap_pkg::*;
#(
  parameter int CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countIn,
  input  cap_strobe_t      strobes,
  input  logic             maskEn,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             irqOut
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValue <= '0;
      capFlag  <= 1'b0;
    end else begin
      if (strobes.capture) capValue <= countIn;
      // A capture takes priority over a clear at the same edge.
      if (strobes.capture)    capFlag <= 1'b1;
      else if (strobes.clear) capFlag <= 1'b0;
    end
  end

  assign irqOut = capFlag & maskEn;
endmodule

// File: rtl/trig_capture.sv
module trig_capture
  import trig_cap_pkg::*;
#(
  parameter int CNT_W       = CNT_W_DEF,
  parameter int SYNC_STAGES = SYNC_DEF,
  parameter int FILT_DEPTH  = FILT_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] countIn,
  input  logic             pinIn,
  input  logic             cmpIn,
  input  logic             srcSel,
  input  logic             edgeSel,
  input  logic             filtEn,
  input  logic             maskEn,
  input  logic             flagWrEn,
  input  logic             flagWrData,
  output logic [CNT_W-1:0] capValue,
  output logic             capFlag,
  output logic             irqOut
);
  cap_strobe_t strobes;

  trig_cap_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .srcSel(srcSel),
    .edgeSel(edgeSel), .filtEn(filtEn), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .strobes(strobes)
  );

  trig_cap_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .countIn(countIn), .strobes(strobes),
    .maskEn(maskEn), .capValue(capValue), .capFlag(capFlag), .irqOut(irqOut)
  );
endmodule

// File: rtl/trig_capture_chk.sv
module trig_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] countIn,
  input logic             maskEn,
  input logic             flagWrEn,
  input logic             flagWrData,
  input logic             capStrobe,
  input logic [CNT_W-1:0] capValue,
  input logic             capFlag,
  input logic             irqOut
);
  p_capture_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |=> (capFlag && capValue == $past(countIn)));

  p_value_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    !capStrobe |=> $stable(capValue));

  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && flagWrData && !capStrobe) |=> !capFlag);

  p_flag_persists_r8: assert property (@(posedge clk) disable iff (!rstN)
    (capFlag && !(flagWrEn && flagWrData)) |=> capFlag);

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskEn && capFlag));
endmodule

bind trig_capture trig_capture_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .countIn(countIn), .maskEn(maskEn),
  .flagWrEn(flagWrEn), .flagWrData(flagWrData), .capStrobe(strobes.capture),
  .capValue(capValue), .capFlag(capFlag), .irqOut(irqOut)
);

// File: tb/trig_capture_tb.sv
module trig_capture_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cnt = 16'h0100;
  logic        pinIn = 1'b0, cmpIn = 1'b0;
  logic        srcSel = 1'b0, edgeSel = 1'b1, filtEn = 1'b0, maskEn = 1'b0;
  logic        flagWrEn = 1'b0, flagWrData = 1'b0;
  logic [15:0] capValue;
  logic        capFlag, irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  trig_capture dut_i (
    .clk(clk), .rstN(rstN), .countIn(cnt), .pinIn(pinIn), .cmpIn(cmpIn),
    .srcSel(srcSel), .edgeSel(edgeSel), .filtEn(filtEn), .maskEn(maskEn),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .capValue(capValue), .capFlag(capFlag), .irqOut(irqOut)
  );

  // {src, edge, filt, newLevel, expectCapture, offset}
  typedef struct packed {
    logic       src;
    logic       edg;
    logic       filt;
    logic       lvl;
    logic       cap;
    logic [3:0] off;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd3},  // R2 R5 pin rising
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R5 falling ignored
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0},  // R5 rising ignored
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R4 pin filtered
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1},  // R3 cmp rising
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R3 cmp falling
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd5},  // R4 cmp filtered
    '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5}   // R4 cmp filtered falling
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearFlag();
    @(negedge clk); flagWrEn = 1'b1; flagWrData = 1'b1;
    @(negedge clk); flagWrEn = 1'b0; flagWrData = 1'b0;
  endtask

  initial begin
    logic [15:0] cnt0;
    logic [15:0] lastCap;
    waitN(3);
    check(capValue == 16'h0 && !capFlag && !irqOut, "R1 reset state", capValue, 0);
    rstN = 1'b1;
    waitN(2);
    lastCap = 16'h0;

    foreach (VECS[k]) begin
      srcSel = VECS[k].src; edgeSel = VECS[k].edg; filtEn = VECS[k].filt;
      clearFlag();
      waitN(10);
      if (VECS[k].src) cmpIn = VECS[k].lvl; else pinIn = VECS[k].lvl;
      cnt0 = cnt;
      waitN(12);
      check(capFlag == VECS[k].cap, $sformatf("R5 R6 vec%0d flag", k), capFlag, VECS[k].cap);
      if (VECS[k].cap) begin
        check(capValue == cnt0 + 16'(VECS[k].off), $sformatf("R2 R3 R4 vec%0d value", k),
              capValue, cnt0 + 16'(VECS[k].off));
        lastCap = capValue;
      end else begin
        check(capValue == lastCap, $sformatf("R5 vec%0d value held", k), capValue, lastCap);
      end
      if (VECS[k].src) pinIn = VECS[k].lvl; else cmpIn = VECS[k].lvl;
      waitN(10);
    end

    // R9 mask gating (flag currently set from last vector)
    maskEn = 1'b0; @(negedge clk);
    check(capFlag && !irqOut, "R9 masked", irqOut, 0);
    maskEn = 1'b1; @(negedge clk);
    check(irqOut, "R9 unmasked", irqOut, 1);

    // R8 write of 0 has no effect, write of 1 clears
    @(negedge clk); flagWrEn = 1'b1; flagWrData = 1'b0;
    @(negedge clk); flagWrEn = 1'b0;
    check(capFlag, "R8 write zero keeps flag", capFlag, 1);
    clearFlag();
    check(!capFlag && !irqOut, "R8 write one clears", capFlag, 0);

    // R6 unselected pin ignored while comparator selected (both levels low)
    srcSel = 1'b1; edgeSel = 1'b1; filtEn = 1'b0;
    waitN(4);
    pinIn = 1'b1; waitN(10);
    check(!capFlag && capValue == lastCap, "R6 unselected pin", capFlag, 0);
    pinIn = 1'b0; waitN(10);
    check(!capFlag && capValue == lastCap, "R6 unselected pin fall", capFlag, 0);

    // R4 short pulse rejected with filter on (pin path)
    srcSel = 1'b0; filtEn = 1'b1; waitN(6);
    pinIn = 1'b1; waitN(3); pinIn = 1'b0;
    waitN(14);
    check(!capFlag && capValue == lastCap, "R4 short pulse rejected", capFlag, 0);

    // R2 same one-cycle pulse accepted without filter
    filtEn = 1'b0; waitN(6);
    pinIn = 1'b1; cnt0 = cnt; @(negedge clk); pinIn = 1'b0;
    waitN(12);
    check(capFlag && capValue == cnt0 + 16'd3, "R2 narrow pulse unfiltered", capValue, cnt0 + 16'd3);

    // R7 overwrite while flag set
    pinIn = 1'b1; cnt0 = cnt; @(negedge clk); pinIn = 1'b0;
    waitN(12);
    check(capFlag && capValue == cnt0 + 16'd3, "R7 overwrite newer count", capValue, cnt0 + 16'd3);

    // R8 capture and clear on the same edge: capture wins
    srcSel = 1'b1; filtEn = 1'b0; edgeSel = 1'b1;
    clearFlag(); waitN(4);
    check(!capFlag, "R8 pre-clear", capFlag, 0);
    cmpIn = 1'b1; cnt0 = cnt;
    @(negedge clk); flagWrEn = 1'b1; flagWrData = 1'b1;
    @(negedge clk); flagWrEn = 1'b0; flagWrData = 1'b0;
    check(capFlag && capValue == cnt0 + 16'd1, "R8 capture beats clear", capValue, cnt0 + 16'd1);
    cmpIn = 1'b0; waitN(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule